// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit processor. For each operation it takes a one-byte opcode, a destination operand, a register source and an immediate source, and it takes the current status nibble. The opcode itself selects which source is used. The block returns the byte to be written back to the destination and a new status nibble carrying sign, overflow and zero. The interrupt-enable bit passes through unchanged. Fetching operands, writing back registers and controlling interrupts belong to the surrounding core.

Work is started by a one-cycle `start` request. A control state machine with four states sequences it:
- `ST_IDLE` accepts a request. It moves to `ST_DIVIDE` for a divide or modulo with a nonzero divisor, and to `ST_ALU` for every other opcode.
- `ST_ALU` produces its result in one clock and moves to `ST_FINISH`.
- `ST_DIVIDE` runs one restoring-division step per clock, W steps in all, and then moves to `ST_FINISH`.
- `ST_FINISH` presents `done` for one cycle and returns to `ST_IDLE`.

`result`, `status_out` and `div_zero` hold their values until the next completion.

Top module: `byte_alu`

## Requirements
- R1: ADD (A0 register, B0 immediate), SUB (A1/B1, destination minus source) and MUL (A2/B2) return the low 8 bits of the sum, the difference or the product.
- R2: DIV (A3/B3) returns the unsigned quotient and MOD (A6/B6) the unsigned remainder of destination by source.
- R3: INC (A4) adds one to the destination and DEC (A5) subtracts one. Both ignore the source inputs.
- R4: AND/OR/XOR use AA/AB/AC with the register source and BA/BB/BC with the immediate source. NOT (AD) inverts the destination.
- R5: The single-position bit operations are ROL 9A (bit 7 enters bit 0), ROR 9B (bit 0 enters bit 7), SHL 9C and SHR 9D. The shifts fill with 0 and discard the bit shifted out.
- R6: Status bits are [0]=Z, [1]=O, [2]=S, [3]=I. For every defined opcode, S equals result bit 7 and Z is set exactly when the result is zero.
- R7: O is the signed two's-complement overflow for ADD, SUB, INC and DEC. For MUL, O is set when the unsigned product exceeds 255. O is 0 for logic, bit, DIV and MOD operations.
- R8: A DIV or MOD with a zero source leaves the result equal to the destination, sets O and raises `div_zero`, with S and Z following the destination.
- R9: `status_out[3]` equals `status_in[3]` sampled at acceptance, for every opcode.
- R10: An undefined opcode returns the destination unchanged, copies `status_in` to `status_out` and keeps `div_zero` low.
- R11: `done` is a one-cycle pulse. It comes 1 clock after the accepting edge, or 8 clocks (W) for DIV/MOD with a nonzero divisor. `busy` is high from acceptance through the `done` cycle, and `start` is ignored while busy.
- R12: After reset, `busy`, `done`, `result`, `status_out` and `div_zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request; sampled in idle only |
| opcode | input | 8 | Operation code |
| dst_val | input | 8 | Destination operand |
| src_reg | input | 8 | Register source operand |
| src_imm | input | 8 | Immediate source operand |
| status_in | input | 4 | Current status {I,S,O,Z} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid pulse |
| result | output | 8 | Value for the destination |
| status_out | output | 4 | New status {I,S,O,Z} |
| div_zero | output | 1 | Divide or modulo by zero occurred |

## Verification
A wrong control state shows at the ports within one to eight clocks. A missing `done`, a second `done` pulse, or a latency other than 1 or 8 clocks is visible in the first completion after the fault. A corrupted division remainder or step counter shows as a wrong quotient or remainder in the same completion. A latched wrong source or flag shows in `result` or `status_out` on that completion. Random opcodes with fixed-seed operands are compared against a bench model, and directed cases pin down the flag boundaries.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALU,
        ST_DIVIDE,
        ST_FINISH
    } alu_state_t;

    typedef enum logic [4:0] {
        K_ADD, K_SUB, K_MUL, K_DIV, K_MOD, K_INC, K_DEC,
        K_AND, K_OR, K_XOR, K_NOT,
        K_ROL, K_ROR, K_SHL, K_SHR,
        K_BAD
    } op_kind_t;

    localparam int FLAG_Z = 0;
    localparam int FLAG_O = 1;
    localparam int FLAG_S = 2;
    localparam int FLAG_I = 3;
    localparam int SR_W   = 4;
endpackage

// File: rtl/byte_alu_decode.sv
module byte_alu_decode
    import byte_alu_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_t   kind,
    output logic       use_imm
);
    always_comb begin
        use_imm = (opcode[7:4] == 4'hB);
        case (opcode)
            8'hA0, 8'hB0: kind = K_ADD;
            8'hA1, 8'hB1: kind = K_SUB;
            8'hA2, 8'hB2: kind = K_MUL;
            8'hA3, 8'hB3: kind = K_DIV;
            8'hA6, 8'hB6: kind = K_MOD;
            8'hA4:        kind = K_INC;
            8'hA5:        kind = K_DEC;
            8'hAA, 8'hBA: kind = K_AND;
            8'hAB, 8'hBB: kind = K_OR;
            8'hAC, 8'hBC: kind = K_XOR;
            8'hAD:        kind = K_NOT;
            8'h9A:        kind = K_ROL;
            8'h9B:        kind = K_ROR;
            8'h9C:        kind = K_SHL;
            8'h9D:        kind = K_SHR;
            default:      kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/byte_alu_exec.sv
module byte_alu_exec
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  op_kind_t       kind,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           ovf
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE     = W'(1);

    logic [2*W-1:0] prod;

    assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    always_comb begin
        res = a;
        ovf = 1'b0;
        case (kind)
            K_ADD: begin
                res = a + b;
                ovf = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
            end
            K_SUB: begin
                res = a - b;
                ovf = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
            end
            K_MUL: begin
                res = prod[W-1:0];
                ovf = |prod[2*W-1:W];
            end
            K_INC: begin
                res = a + ONE;
                ovf = (a == MAX_POS);
            end
            K_DEC: begin
                res = a - ONE;
                ovf = (a == MIN_NEG);
            end
            K_AND: res = a & b;
            K_OR:  res = a | b;
            K_XOR: res = a ^ b;
            K_NOT: res = ~a;
            K_ROL: res = {a[W-2:0], a[W-1]};
            K_ROR: res = {a[0], a[W-1:1]};
            K_SHL: res = {a[W-2:0], 1'b0};
            K_SHR: res = {1'b0, a[W-1:1]};
            default: res = a;
        endcase
    end
endmodule

// File: rtl/byte_alu_divstep.sv
module byte_alu_divstep #(
    parameter int W = 8
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] rem_n,
    output logic [W-1:0] quo_n
);
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        shifted = {rem, quo[W-1]};
        trial   = shifted - {1'b0, divisor};
        if (!trial[W]) begin
            rem_n = trial[W-1:0];
            quo_n = {quo[W-2:0], 1'b1};
        end else begin
            rem_n = shifted[W-1:0];
            quo_n = {quo[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      opcode,
    input  logic [W-1:0]    dst_val,
    input  logic [W-1:0]    src_reg,
    input  logic [W-1:0]    src_imm,
    input  logic [SR_W-1:0] status_in,
    output logic            busy,
    output logic            done,
    output logic [W-1:0]    result,
    output logic [SR_W-1:0] status_out,
    output logic            div_zero
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    alu_state_t      state, state_n;
    op_kind_t        kind_in, kind_q;
    logic            use_imm;
    logic [W-1:0]    src_sel;
    logic            in_is_div;
    logic [W-1:0]    a_q, b_q;
    logic [SR_W-1:0] sr_q;
    logic [W-1:0]    rem_q, quo_q, rem_n, quo_n;
    logic [CW-1:0]   cnt_q;
    logic [W-1:0]    exec_res;
    logic            exec_ovf;
    logic [W-1:0]    div_res;
    logic [W-1:0]    result_q;
    logic [SR_W-1:0] status_q;
    logic            dz_q;

    byte_alu_decode u_decode (
        .opcode  (opcode),
        .kind    (kind_in),
        .use_imm (use_imm)
    );

    byte_alu_exec #(.W(W)) u_exec (
        .kind (kind_q),
        .a    (a_q),
        .b    (b_q),
        .res  (exec_res),
        .ovf  (exec_ovf)
    );

    byte_alu_divstep #(.W(W)) u_divstep (
        .rem     (rem_q),
        .quo     (quo_q),
        .divisor (b_q),
        .rem_n   (rem_n),
        .quo_n   (quo_n)
    );

    assign src_sel   = use_imm ? src_imm : src_reg;
    assign in_is_div = (kind_in == K_DIV) || (kind_in == K_MOD);
    assign div_res   = (kind_q == K_DIV) ? quo_n : rem_n;

    function automatic logic [SR_W-1:0] pack_sr(input logic i_bit,
                                                input logic [W-1:0] r,
                                                input logic o_bit);
        logic [SR_W-1:0] s;
        s         = '0;
        s[FLAG_I] = i_bit;
        s[FLAG_S] = r[W-1];
        s[FLAG_O] = o_bit;
        s[FLAG_Z] = (r == '0);
        return s;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (in_is_div && (src_sel != '0)) state_n = ST_DIVIDE;
                    else                              state_n = ST_ALU;
                end
            end
            ST_ALU:    state_n = ST_FINISH;
            ST_DIVIDE: if (cnt_q == LAST_STEP) state_n = ST_FINISH;
            ST_FINISH: state_n = ST_IDLE;
        endcase
    end

    // operand latch and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= K_BAD;
            a_q      <= '0;
            b_q      <= '0;
            sr_q     <= '0;
            rem_q    <= '0;
            quo_q    <= '0;
            cnt_q    <= '0;
            result_q <= '0;
            status_q <= '0;
            dz_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        kind_q <= kind_in;
                        a_q    <= dst_val;
                        b_q    <= src_sel;
                        sr_q   <= status_in;
                        rem_q  <= '0;
                        quo_q  <= dst_val;
                        cnt_q  <= '0;
                    end
                end
                ST_ALU: begin
                    if (kind_q == K_BAD) begin
                        result_q <= a_q;
                        status_q <= sr_q;
                        dz_q     <= 1'b0;
                    end else if ((kind_q == K_DIV) || (kind_q == K_MOD)) begin
                        result_q <= a_q;
                        status_q <= pack_sr(sr_q[FLAG_I], a_q, 1'b1);
                        dz_q     <= 1'b1;
                    end else begin
                        result_q <= exec_res;
                        status_q <= pack_sr(sr_q[FLAG_I], exec_res, exec_ovf);
                        dz_q     <= 1'b0;
                    end
                end
                ST_DIVIDE: begin
                    rem_q <= rem_n;
                    quo_q <= quo_n;
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == LAST_STEP) begin
                        result_q <= div_res;
                        status_q <= pack_sr(sr_q[FLAG_I], div_res, 1'b0);
                        dz_q     <= 1'b0;
                    end
                end
                ST_FINISH: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_FINISH);
        result     = result_q;
        status_out = status_q;
        div_zero   = dz_q;
    end

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> busy);

    a_r11_divide_length: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIVIDE && cnt_q == LAST_STEP) |=> done);

    a_r9_i_passes: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status_out[FLAG_I] == sr_q[FLAG_I]));

    a_r8_div_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (status_out[FLAG_O] && result == a_q));

    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q != K_BAD) |-> (status_out[FLAG_Z] == (result == '0)));

    a_r10_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == K_BAD) |-> (status_out == sr_q && !div_zero));
endmodule

// File: tb/byte_alu_bench.sv
module byte_alu_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [7:0] dst_val = 8'h00;
    logic [7:0] src_reg = 8'h00;
    logic [7:0] src_imm = 8'h00;
    logic [3:0] status_in = 4'h0;
    logic       busy, done, div_zero;
    logic [7:0] result;
    logic [3:0] status_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    byte_alu u_byte_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .dst_val(dst_val), .src_reg(src_reg), .src_imm(src_imm),
        .status_in(status_in), .busy(busy), .done(done),
        .result(result), .status_out(status_out), .div_zero(div_zero)
    );

    localparam logic [7:0] OPS [23] = '{
        8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hAA, 8'hAB, 8'hAC, 8'hAD,
        8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB6, 8'hBA, 8'hBB, 8'hBC,
        8'h9A, 8'h9B, 8'h9C, 8'h9D};

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_defined(input logic [7:0] op);
        foreach (OPS[k]) if (OPS[k] == op) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string req_of(input logic [7:0] op);
        case (op)
            8'hA0, 8'hA1, 8'hA2, 8'hB0, 8'hB1, 8'hB2: return "R1";
            8'hA3, 8'hA6, 8'hB3, 8'hB6: return "R2";
            8'hA4, 8'hA5: return "R3";
            8'hAA, 8'hAB, 8'hAC, 8'hAD, 8'hBA, 8'hBB, 8'hBC: return "R4";
            8'h9A, 8'h9B, 8'h9C, 8'h9D: return "R5";
            default: return "R10";
        endcase
    endfunction

    // returns {div_zero, status[3:0], result[7:0]}
    function automatic logic [12:0] model(input logic [7:0] op, input logic [7:0] d,
                                          input logic [7:0] sr, input logic [7:0] si,
                                          input logic [3:0] st);
        logic [7:0]  b, r;
        logic        o;
        logic        dz;
        logic [15:0] p;
        b  = (op[7:4] == 4'hB) ? si : sr;
        o  = 1'b0;
        dz = 1'b0;
        r  = d;
        if (!is_defined(op)) return {1'b0, st, d};
        case (op)
            8'hA0, 8'hB0: begin r = d + b; o = ($signed(d) + $signed(b) > 127) || ($signed(d) + $signed(b) < -128); end
            8'hA1, 8'hB1: begin r = d - b; o = ($signed(d) - $signed(b) > 127) || ($signed(d) - $signed(b) < -128); end
            8'hA2, 8'hB2: begin p = d * b; r = p[7:0]; o = (p > 16'd255); end
            8'hA3, 8'hB3: if (b == 0) begin dz = 1; o = 1; end else r = d / b;
            8'hA6, 8'hB6: if (b == 0) begin dz = 1; o = 1; end else r = d % b;
            8'hA4: begin r = d + 1; o = (d == 8'h7F); end
            8'hA5: begin r = d - 1; o = (d == 8'h80); end
            8'hAA, 8'hBA: r = d & b;
            8'hAB, 8'hBB: r = d | b;
            8'hAC, 8'hBC: r = d ^ b;
            8'hAD: r = ~d;
            8'h9A: r = {d[6:0], d[7]};
            8'h9B: r = {d[0], d[7:1]};
            8'h9C: r = d << 1;
            8'h9D: r = d >> 1;
            default: r = d;
        endcase
        return {dz, st[3], r[7], o, (r == 8'h00), r};
    endfunction

    // runs one operation; junk=1 keeps start high with another opcode while busy
    task automatic run_op(input logic [7:0] op, input logic [7:0] d, input logic [7:0] sr,
                          input logic [7:0] si, input logic [3:0] st, input bit junk);
        logic [12:0] exp;
        int lat;
        string rq;
        bit is_div;
        exp = model(op, d, sr, si, st);
        rq  = req_of(op);
        is_div = (op == 8'hA3 || op == 8'hA6 || op == 8'hB3 || op == 8'hB6) &&
                 (((op[7:4] == 4'hB) ? si : sr) != 8'h00);
        @(negedge clk);
        opcode = op; dst_val = d; src_reg = sr; src_imm = si; status_in = st; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (junk) begin
            opcode = 8'hAD; dst_val = ~d; status_in = ~st;
        end else start = 1'b0;
        lat = 0;
        chk("R11", "busy after accept", busy, 1);
        while (!done && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R11", "latency", lat, is_div ? 8 : 1);
        chk(rq, "result", result, exp[7:0]);
        chk(exp[11] == 0 && is_defined(op) ? "R7" : rq, "status", status_out, exp[11:8]);
        chk("R6", "S and Z", {status_out[2], status_out[0]}, {exp[10], exp[8]});
        chk("R9", "I flag", status_out[3], st[3]);
        chk(exp[12] ? "R8" : rq, "div_zero", div_zero, exp[12]);
        chk("R11", "busy in done cycle", busy, 1);
        @(posedge clk);
        @(negedge clk);
        chk("R11", "done single pulse", done, 0);
    endtask

    initial begin
        logic [7:0] op;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", "reset busy", busy, 0);
        chk("R12", "reset done", done, 0);
        chk("R12", "reset result", result, 0);
        chk("R12", "reset status", status_out, 0);
        chk("R12", "reset div_zero", div_zero, 0);
        rst_n = 1'b1;

        // directed corners
        run_op(8'hA0, 8'h7F, 8'h01, 8'h00, 4'h0, 0);  // R1 R7 ADD overflow
        run_op(8'hB1, 8'h80, 8'h00, 8'h01, 4'h8, 0);  // R1 R7 SUB overflow, immediate
        run_op(8'hB2, 8'h10, 8'h00, 8'h10, 4'h0, 0);  // R1 R7 MUL wraps to zero
        run_op(8'hA3, 8'h64, 8'h07, 8'h00, 4'h0, 0);  // R2 quotient 0E
        run_op(8'hB6, 8'h64, 8'h00, 8'h07, 4'h8, 0);  // R2 remainder 02
        run_op(8'hA3, 8'hFF, 8'h01, 8'h00, 4'h0, 0);  // R2 divide by one
        run_op(8'hA3, 8'h85, 8'h00, 8'h09, 4'h8, 0);  // R8 divide by zero
        run_op(8'hB6, 8'h00, 8'h05, 8'h00, 4'h0, 0);  // R8 modulo by zero, zero dest
        run_op(8'hA4, 8'h7F, 8'hFF, 8'hFF, 4'h0, 0);  // R3 INC overflow
        run_op(8'hA5, 8'h80, 8'h12, 8'h34, 4'h0, 0);  // R3 DEC overflow
        run_op(8'hAD, 8'h5A, 8'h00, 8'h00, 4'h0, 0);  // R4 NOT
        run_op(8'hBA, 8'hF0, 8'hFF, 8'h55, 4'h0, 0);  // R4 AND immediate
        run_op(8'h9A, 8'h81, 8'h00, 8'h00, 4'h0, 0);  // R5 ROL
        run_op(8'h9B, 8'h01, 8'h00, 8'h00, 4'h0, 0);  // R5 ROR
        run_op(8'h9C, 8'h81, 8'h00, 8'h00, 4'h0, 0);  // R5 SHL
        run_op(8'h9D, 8'h81, 8'h00, 8'h00, 4'h0, 0);  // R5 SHR
        run_op(8'h42, 8'h33, 8'h11, 8'h22, 4'h5, 0);  // R10 undefined opcode
        run_op(8'hA0, 8'h01, 8'h02, 8'h00, 4'h8, 1);  // R11 start ignored while busy
        run_op(8'hA6, 8'hC8, 8'h0D, 8'h00, 4'h0, 1);  // R11 ignored during divide

        // constrained random
        for (int n = 0; n < 1500; n++) begin
            if ($urandom_range(0, 15) == 0) op = 8'($urandom);
            else op = OPS[$urandom_range(0, 22)];
            run_op(op, 8'($urandom), 8'($urandom_range(0, 3) == 0 ? 0 : $urandom),
                   8'($urandom_range(0, 3) == 0 ? 0 : $urandom), 4'($urandom),
                   $urandom_range(0, 7) == 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule